// File: doc/BRIEF.md
# Relative Branch and Call Unit

This unit computes the next instruction pointer of a small 8-bit processor. Each instruction arrives as an opcode byte and an operand byte, together with the current pointer, the Z, S and O condition flags and a valid strobe. The unit then produces the next pointer. It handles plain sequential advance, seven flavours of relative jump, absolute calls and software interrupts that fetch their target from a memory vector. It also handles returns through a downward-growing stack.

The same stack pointer serves register pushes and pops and status-byte pushes and pops. Popped data is handed back with a write strobe that is specific to the register or to the status byte. All stack and vector traffic goes through one synchronous memory port. That port has a one-cycle read latency: an address that is sampled at an edge returns its data during the following cycle.

Jumps, calls, pushes and sequential steps finish in one cycle. Pops and returns finish in three cycles, and software interrupts in four. While an operation is in progress the unit reports itself busy and drops any new request.

Top module: `rel_branch_unit`

## Requirements
- R1: After reset, `busy`, `ip_valid`, `mem_en`, `pop_reg_wr` and `pop_sr_wr` are 0, and `sp_out` is 0xBF.
- R2: Opcodes 0xC0 to 0xC6 are jumps. 0xC0 is always taken. 0xC1 is taken on Z and 0xC2 on not Z. 0xC3 is taken on S and 0xC4 on not S. 0xC5 is taken on O and 0xC6 on not O. A taken jump gives `ip_out` = `ip_in` + the sign-extended operand, modulo 256, with `ip_valid` high in the first cycle after acceptance.
- R3: A jump whose condition fails gives `ip_out` = `ip_in` + 2 in the first cycle after acceptance.
- R4: Opcode 0xCA writes `ip_in`+2 to memory at the current stack pointer, then decrements the pointer and sets `ip_out` to the operand. The result is due in the first cycle after acceptance.
- R5: Opcodes 0xCB and 0xCD increment the stack pointer, read memory at the new pointer and set `ip_out` to the byte read. `ip_valid` rises in the third cycle after acceptance.
- R6: Opcode 0xCC writes `ip_in`+2 at the stack pointer and decrements the pointer. It then reads memory at the address given by the operand and sets `ip_out` to that byte. `ip_valid` rises in the fourth cycle after acceptance.
- R7: Opcode 0xE0 pushes `push_reg` and gives `ip_out` = `ip_in`+2. Opcode 0xEA pushes `push_sr` and gives `ip_out` = `ip_in`+1. Both write at the stack pointer, decrement it and finish in the first cycle.
- R8: Opcode 0xE1 pops into `pop_data` with `pop_reg_wr` and gives `ip_out` = `ip_in`+2. Opcode 0xEB pops with `pop_sr_wr` and gives `ip_out` = `ip_in`+1. Both finish in the third cycle.
- R9: Any other opcode gives `ip_out` = `ip_in` + `instr_len` in the first cycle. It makes no memory access and leaves the stack pointer unchanged.
- R10: A request presented while `busy` is high is ignored. The stack pointer holds and no extra `ip_valid` follows.
- R11: The stack pointer wraps modulo 256: a push at 0x00 leaves 0xFF, and a pop at 0xFF leaves 0x00.
- R12: Only opcode 0xEB raises `pop_sr_wr`. Jumps, calls, returns and interrupts never drive the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Opcode and operand present |
| opcode | input | 8 | Instruction opcode |
| operand | input | 8 | Offset, address, vector index |
| ip_in | input | 8 | Pointer of this instruction |
| instr_len | input | 2 | Length for sequential opcodes |
| flag_z | input | 1 | Zero flag |
| flag_s | input | 1 | Sign flag |
| flag_o | input | 1 | Overflow flag |
| push_reg | input | 8 | Register value for 0xE0 |
| push_sr | input | 8 | Status byte for 0xEA |
| busy | output | 1 | Operation in progress |
| ip_valid | output | 1 | `ip_out` holds the next pointer |
| ip_out | output | 8 | Next instruction pointer |
| sp_out | output | 8 | Stack pointer |
| pop_data | output | 8 | Popped byte |
| pop_reg_wr | output | 1 | Write `pop_data` to a register |
| pop_sr_wr | output | 1 | Write `pop_data` to the status byte |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after the address |

## Verification
Every result is registered. Jumps, calls, pushes and sequential steps are due in the first cycle after the accepting edge. Pops and returns are due in the third cycle, because the read address is registered and the memory adds a cycle of latency before the data is captured. Interrupts spend one more cycle on their write and are due in the fourth. The bench drives its inputs and samples on the falling edge, and it counts those falling edges from acceptance. It checks that `ip_valid` stays low in the earlier cycles and tests the result exactly in its due cycle.

// File: rtl/bu_pkg.sv
package bu_pkg;
    localparam logic [7:0] OP_JMP_BASE = 8'hC0;
    localparam logic [7:0] OP_CALL     = 8'hCA;
    localparam logic [7:0] OP_RET      = 8'hCB;
    localparam logic [7:0] OP_SWI      = 8'hCC;
    localparam logic [7:0] OP_SWI_RET  = 8'hCD;
    localparam logic [7:0] OP_PUSH_R   = 8'hE0;
    localparam logic [7:0] OP_POP_R    = 8'hE1;
    localparam logic [7:0] OP_PUSH_SR  = 8'hEA;
    localparam logic [7:0] OP_POP_SR   = 8'hEB;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_VECW,
        ST_RDWAIT,
        ST_CAPT
    } bu_state_e;

    typedef enum logic [1:0] {
        K_IP,
        K_REG,
        K_SR
    } bu_kind_e;
endpackage

// File: rtl/bu_cond.sv
module bu_cond (
    input  logic [2:0] sel,
    input  logic       z,
    input  logic       s,
    input  logic       o,
    output logic       take
);
    always_comb begin
        case (sel)
            3'd0:    take = 1'b1;
            3'd1:    take = z;
            3'd2:    take = !z;
            3'd3:    take = s;
            3'd4:    take = !s;
            3'd5:    take = o;
            3'd6:    take = !o;
            default: take = 1'b0;
        endcase
    end
endmodule

// File: rtl/bu_target.sv
module bu_target #(
    parameter int W    = 8,
    parameter int LENW = 2
) (
    input  logic [W-1:0]    ip,
    input  logic [W-1:0]    disp,
    input  logic [LENW-1:0] len,
    output logic [W-1:0]    rel_tgt,
    output logic [W-1:0]    nxt1,
    output logic [W-1:0]    nxt2,
    output logic [W-1:0]    nxtn
);
    localparam logic [W-1:0] ONE = W'(1);
    localparam logic [W-1:0] TWO = W'(2);

    always_comb begin
        rel_tgt = ip + disp;
        nxt1    = ip + ONE;
        nxt2    = ip + TWO;
        nxtn    = ip + {{(W-LENW){1'b0}}, len};
    end
endmodule

// File: rtl/rel_branch_unit.sv
module rel_branch_unit
    import bu_pkg::*;
#(
    parameter int         W       = 8,
    parameter int         LENW    = 2,
    parameter logic [7:0] SP_INIT = 8'hBF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_valid,
    input  logic [7:0]      opcode,
    input  logic [W-1:0]    operand,
    input  logic [W-1:0]    ip_in,
    input  logic [LENW-1:0] instr_len,
    input  logic            flag_z,
    input  logic            flag_s,
    input  logic            flag_o,
    input  logic [W-1:0]    push_reg,
    input  logic [W-1:0]    push_sr,
    output logic            busy,
    output logic            ip_valid,
    output logic [W-1:0]    ip_out,
    output logic [W-1:0]    sp_out,
    output logic [W-1:0]    pop_data,
    output logic            pop_reg_wr,
    output logic            pop_sr_wr,
    output logic            mem_en,
    output logic            mem_we,
    output logic [W-1:0]    mem_addr,
    output logic [W-1:0]    mem_wdata,
    input  logic [W-1:0]    mem_rdata
);
    localparam logic [W-1:0] SP_ONE = W'(1);

    typedef struct packed {
        bu_state_e    state;
        bu_kind_e     kind;
        logic [W-1:0] ip;
        logic [W-1:0] sp;
        logic [W-1:0] vec;
        logic         done;
        logic [W-1:0] pdata;
        logic         preg;
        logic         psr;
        logic         men;
        logic         mwe;
        logic [W-1:0] maddr;
        logic [W-1:0] mwdata;
    } bu_regs_t;

    bu_regs_t r_q, r_d;

    logic         take;
    logic [W-1:0] rel_tgt, nxt1, nxt2, nxtn;
    logic         is_jump;

    assign is_jump = (opcode[7:3] == OP_JMP_BASE[7:3]) && (opcode[2:0] != 3'b111);

    bu_cond u_cond (
        .sel  (opcode[2:0]),
        .z    (flag_z),
        .s    (flag_s),
        .o    (flag_o),
        .take (take)
    );

    bu_target #(.W(W), .LENW(LENW)) u_tgt (
        .ip      (ip_in),
        .disp    (operand),
        .len     (instr_len),
        .rel_tgt (rel_tgt),
        .nxt1    (nxt1),
        .nxt2    (nxt2),
        .nxtn    (nxtn)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.preg = 1'b0;
        r_d.psr  = 1'b0;
        r_d.men  = 1'b0;
        r_d.mwe  = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (instr_valid) begin
                    if (is_jump) begin
                        r_d.ip   = take ? rel_tgt : nxt2;
                        r_d.done = 1'b1;
                    end else begin
                        case (opcode)
                            OP_CALL, OP_SWI, OP_PUSH_R, OP_PUSH_SR: begin
                                r_d.men   = 1'b1;
                                r_d.mwe   = 1'b1;
                                r_d.maddr = r_q.sp;
                                r_d.sp    = r_q.sp - SP_ONE;
                                case (opcode)
                                    OP_CALL: begin
                                        r_d.mwdata = nxt2;
                                        r_d.ip     = operand;
                                        r_d.done   = 1'b1;
                                    end
                                    OP_SWI: begin
                                        r_d.mwdata = nxt2;
                                        r_d.vec    = operand;
                                        r_d.state  = ST_VECW;
                                    end
                                    OP_PUSH_R: begin
                                        r_d.mwdata = push_reg;
                                        r_d.ip     = nxt2;
                                        r_d.done   = 1'b1;
                                    end
                                    default: begin
                                        r_d.mwdata = push_sr;
                                        r_d.ip     = nxt1;
                                        r_d.done   = 1'b1;
                                    end
                                endcase
                            end
                            OP_RET, OP_SWI_RET, OP_POP_R, OP_POP_SR: begin
                                r_d.sp    = r_q.sp + SP_ONE;
                                r_d.men   = 1'b1;
                                r_d.maddr = r_q.sp + SP_ONE;
                                r_d.state = ST_RDWAIT;
                                case (opcode)
                                    OP_POP_R: begin
                                        r_d.kind = K_REG;
                                        r_d.ip   = nxt2;
                                    end
                                    OP_POP_SR: begin
                                        r_d.kind = K_SR;
                                        r_d.ip   = nxt1;
                                    end
                                    default: r_d.kind = K_IP;
                                endcase
                            end
                            default: begin
                                r_d.ip   = nxtn;
                                r_d.done = 1'b1;
                            end
                        endcase
                    end
                end
            end
            ST_VECW: begin
                r_d.men   = 1'b1;
                r_d.maddr = r_q.vec;
                r_d.kind  = K_IP;
                r_d.state = ST_RDWAIT;
            end
            ST_RDWAIT: begin
                r_d.state = ST_CAPT;
            end
            default: begin
                case (r_q.kind)
                    K_REG: begin
                        r_d.pdata = mem_rdata;
                        r_d.preg  = 1'b1;
                    end
                    K_SR: begin
                        r_d.pdata = mem_rdata;
                        r_d.psr   = 1'b1;
                    end
                    default: r_d.ip = mem_rdata;
                endcase
                r_d.done  = 1'b1;
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.state  <= ST_IDLE;
            r_q.kind   <= K_IP;
            r_q.sp     <= SP_INIT[W-1:0];
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = (r_q.state != ST_IDLE);
    assign ip_valid   = r_q.done;
    assign ip_out     = r_q.ip;
    assign sp_out     = r_q.sp;
    assign pop_data   = r_q.pdata;
    assign pop_reg_wr = r_q.preg;
    assign pop_sr_wr  = r_q.psr;
    assign mem_en     = r_q.men;
    assign mem_we     = r_q.mwe;
    assign mem_addr   = r_q.maddr;
    assign mem_wdata  = r_q.mwdata;
endmodule

// File: rtl/bu_checker.sv
module bu_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         instr_valid,
    input logic [7:0]   opcode,
    input logic         busy,
    input logic         ip_valid,
    input logic [W-1:0] sp_out,
    input logic         mem_en,
    input logic         mem_we,
    input logic [W-1:0] mem_addr,
    input logic         pop_reg_wr,
    input logic         pop_sr_wr
);
    localparam logic [W-1:0] ONE = W'(1);

    AST_POP_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_reg_wr || pop_sr_wr) |-> (ip_valid && !(pop_reg_wr && pop_sr_wr))); // R8

    AST_PUSH_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_en && (sp_out == mem_addr - ONE))); // R7

    AST_BUSY_SP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(sp_out)); // R10

    AST_JUMP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !busy && opcode[7:3] == 5'b11000 && opcode[2:0] != 3'b111) |=> ip_valid); // R2

    AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !instr_valid) |=> !ip_valid); // R10
endmodule

bind rel_branch_unit bu_checker #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .opcode      (opcode),
    .busy        (busy),
    .ip_valid    (ip_valid),
    .sp_out      (sp_out),
    .mem_en      (mem_en),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .pop_reg_wr  (pop_reg_wr),
    .pop_sr_wr   (pop_sr_wr)
);

// File: tb/rel_branch_unit_tb.sv
module rel_branch_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       instr_valid = 1'b0;
    logic [7:0] opcode = 8'h00, operand = 8'h00, ip_in = 8'h00;
    logic [1:0] instr_len = 2'd0;
    logic       flag_z = 1'b0, flag_s = 1'b0, flag_o = 1'b0;
    logic [7:0] push_reg = 8'h00, push_sr = 8'h00;
    logic       busy, ip_valid, pop_reg_wr, pop_sr_wr, mem_en, mem_we;
    logic [7:0] ip_out, sp_out, pop_data, mem_addr, mem_wdata;
    logic [7:0] mem_rdata = 8'h00;
    logic [7:0] mem [256];

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    rel_branch_unit u_dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .opcode(opcode),
        .operand(operand), .ip_in(ip_in), .instr_len(instr_len),
        .flag_z(flag_z), .flag_s(flag_s), .flag_o(flag_o),
        .push_reg(push_reg), .push_sr(push_sr), .busy(busy), .ip_valid(ip_valid),
        .ip_out(ip_out), .sp_out(sp_out), .pop_data(pop_data),
        .pop_reg_wr(pop_reg_wr), .pop_sr_wr(pop_sr_wr), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata     <= mem[mem_addr];
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present one instruction; returns in the first cycle after acceptance.
    task automatic issue(input logic [7:0] op, input logic [7:0] opr,
                         input logic [7:0] ipv, input logic [1:0] len);
        @(negedge clk);
        instr_valid = 1'b1; opcode = op; operand = opr; ip_in = ipv; instr_len = len;
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 busy", busy, 0);
        check("R1 ip_valid", ip_valid, 0);
        check("R1 mem_en", mem_en, 0);
        check("R1 pop strobes", {pop_reg_wr, pop_sr_wr}, 0);
        check("R1 sp", sp_out, 8'hBF);
    endtask

    task automatic jump(input logic [7:0] op, input logic [7:0] opr, input logic [7:0] ipv,
                        input logic z, input logic s, input logic o, input logic [7:0] exp,
                        input string req);
        flag_z = z; flag_s = s; flag_o = o;
        issue(op, opr, ipv, 2'd0);
        check(req, ip_valid, 1);
        check(req, ip_out, exp);
        check("R12 no sr strobe on jump", pop_sr_wr, 0);
    endtask

    task automatic t_jumps;
        jump(8'hC0, 8'h12, 8'h10, 0, 0, 0, 8'h22, "R2 jmp fwd");
        jump(8'hC0, 8'hFE, 8'h10, 0, 0, 0, 8'h0E, "R2 jmp back 2");
        jump(8'hC0, 8'h20, 8'hF0, 0, 0, 0, 8'h10, "R2 jmp wrap");
        jump(8'hC0, 8'h80, 8'h10, 0, 0, 0, 8'h90, "R2 jmp -128");
        jump(8'hC0, 8'h7F, 8'h90, 0, 0, 0, 8'h0F, "R2 jmp +127");
        jump(8'hC1, 8'h9C, 8'h80, 1, 0, 0, 8'h1C, "R2 jz taken");
        jump(8'hC1, 8'h9C, 8'h80, 0, 1, 1, 8'h82, "R3 jz not taken");
        jump(8'hC2, 8'h04, 8'h30, 0, 0, 0, 8'h34, "R2 jnz taken");
        jump(8'hC2, 8'h04, 8'h30, 1, 0, 0, 8'h32, "R3 jnz not taken");
        jump(8'hC3, 8'hE1, 8'h40, 0, 1, 0, 8'h21, "R2 js taken");
        jump(8'hC3, 8'hE1, 8'h40, 1, 0, 1, 8'h42, "R3 js not taken");
        jump(8'hC4, 8'hE0, 8'h40, 0, 0, 0, 8'h20, "R2 jns taken");
        jump(8'hC4, 8'hE0, 8'h40, 0, 1, 0, 8'h42, "R3 jns not taken");
        jump(8'hC5, 8'hDF, 8'h50, 0, 0, 1, 8'h2F, "R2 jo taken");
        jump(8'hC5, 8'hDF, 8'h50, 1, 1, 0, 8'h52, "R3 jo not taken");
        jump(8'hC6, 8'hFB, 8'h50, 0, 0, 0, 8'h4B, "R2 jno taken");
        jump(8'hC6, 8'hFB, 8'h50, 0, 0, 1, 8'h52, "R3 jno not taken");
        check("R2 sp unchanged by jumps", sp_out, 8'hBF);
    endtask

    task automatic t_call;
        issue(8'hCA, 8'h30, 8'h20, 2'd0);
        check("R4 call valid", ip_valid, 1);
        check("R4 call target", ip_out, 8'h30);
        check("R4 call sp", sp_out, 8'hBE);
        check("R12 call no sr strobe", pop_sr_wr, 0);
        @(negedge clk);
        check("R4 call pushed return", mem[8'hBF], 8'h22);
    endtask

    task automatic t_ret_busy;
        issue(8'hCB, 8'h00, 8'h30, 2'd0);
        check("R5 ret busy c1", busy, 1);
        check("R5 ret not done c1", ip_valid, 0);
        check("R5 ret sp", sp_out, 8'hBF);
        instr_valid = 1'b1; opcode = 8'hC0; operand = 8'h10; ip_in = 8'h00;
        @(negedge clk);
        instr_valid = 1'b0;
        check("R10 no done c2", ip_valid, 0);
        @(negedge clk);
        check("R5 ret done c3", ip_valid, 1);
        check("R5 ret target", ip_out, 8'h22);
        @(negedge clk);
        check("R10 ignored jump gives no done", ip_valid, 0);
        check("R10 sp held", sp_out, 8'hBF);
    endtask

    task automatic t_int;
        mem[8'h02] = 8'h55;
        issue(8'hCC, 8'h02, 8'h40, 2'd0);
        check("R6 int sp", sp_out, 8'hBE);
        @(negedge clk);
        @(negedge clk);
        check("R6 int not done c3", ip_valid, 0);
        check("R6 int pushed return", mem[8'hBF], 8'h42);
        @(negedge clk);
        check("R6 int done c4", ip_valid, 1);
        check("R6 int vector target", ip_out, 8'h55);
        check("R12 int no sr strobe", pop_sr_wr, 0);
        issue(8'hCD, 8'h00, 8'h55, 2'd0);
        @(negedge clk);
        @(negedge clk);
        check("R5 iret done", ip_valid, 1);
        check("R5 iret target", ip_out, 8'h42);
        check("R5 iret sp", sp_out, 8'hBF);
    endtask

    task automatic t_stack;
        push_reg = 8'hA5; push_sr = 8'h0C;
        issue(8'hE0, 8'h01, 8'h50, 2'd0);
        check("R7 push ip", ip_out, 8'h52);
        check("R7 push valid", ip_valid, 1);
        check("R7 push sp", sp_out, 8'hBE);
        issue(8'hEA, 8'h00, 8'h52, 2'd0);
        check("R7 pushf ip", ip_out, 8'h53);
        check("R7 pushf sp", sp_out, 8'hBD);
        @(negedge clk);
        check("R7 push data", mem[8'hBF], 8'hA5);
        check("R7 pushf data", mem[8'hBE], 8'h0C);
        issue(8'hEB, 8'h00, 8'h53, 2'd0);
        @(negedge clk);
        check("R8 popf not done c2", ip_valid, 0);
        @(negedge clk);
        check("R8 popf done", ip_valid, 1);
        check("R8 popf data", pop_data, 8'h0C);
        check("R12 popf sr strobe", pop_sr_wr, 1);
        check("R8 popf no reg strobe", pop_reg_wr, 0);
        check("R8 popf ip", ip_out, 8'h54);
        check("R8 popf sp", sp_out, 8'hBE);
        issue(8'hE1, 8'h02, 8'h54, 2'd0);
        @(negedge clk);
        @(negedge clk);
        check("R8 pop data", pop_data, 8'hA5);
        check("R8 pop reg strobe", pop_reg_wr, 1);
        check("R12 pop no sr strobe", pop_sr_wr, 0);
        check("R8 pop ip", ip_out, 8'h56);
        check("R8 pop sp", sp_out, 8'hBF);
    endtask

    task automatic t_seq;
        issue(8'hA0, 8'h01, 8'h60, 2'd3);
        check("R9 seq valid", ip_valid, 1);
        check("R9 seq ip", ip_out, 8'h63);
        check("R9 seq no mem", mem_en, 0);
        check("R9 seq sp", sp_out, 8'hBF);
        issue(8'hFF, 8'h00, 8'hFF, 2'd1);
        check("R9 seq wrap ip", ip_out, 8'h00);
    endtask

    task automatic t_wrap;
        push_reg = 8'h3C;
        for (int i = 0; i < 192; i++) issue(8'hE0, 8'h00, 8'h00, 2'd0);
        check("R11 push wraps to FF", sp_out, 8'hFF);
        issue(8'hE1, 8'h00, 8'h00, 2'd0);
        check("R11 pop wraps to 00", sp_out, 8'h00);
        @(negedge clk);
        @(negedge clk);
        check("R11 pop data at 00", pop_data, 8'h3C);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_jumps();
        t_call();
        t_ret_busy();
        t_int();
        t_stack();
        t_seq();
        t_wrap();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule